// File: doc/BRIEF.md
# DMA Channel Run Control and Status Flags

This block holds the run control for a single DMA channel. Software starts and stops the channel through a small set of register-style write strobes: an active bit, an interrupt-enable bit and a block-error flag. It also programs a block length and a transfer count. A peripheral raises transfer requests. The block turns each accepted request into one bus cycle in single mode, or into a whole run of bus cycles in block mode. Each bus cycle is a start/done handshake with the bus side, which is outside this block.

The block decides when the channel may stop. A software stop never cuts a bus cycle short. In block mode it also never cuts a block short. An NMI or a standby entry stops the channel at the end of the bus cycle in flight. An NMI that stops a block partway sets the block-error flag. When the transfer count runs out, the channel clears its active bit and raises the interrupt-request flag. Setting the active bit again clears that flag.

Top module: `dmac_chan_ctrl`

## Requirements
- R1: After reset, the following are all 0: the active bit, the interrupt-enable bit, the block-error flag, the interrupt-request flag, the interrupt output, bus_start and the remaining transfer count.
- R2: With blk_mode=1, a single accepted request produces exactly the programmed block length of bus cycles, one after another. A software stop written during the block takes effect only after the last cycle of that block.
- R3: An NMI during a block lets the bus cycle in flight finish and issues no further cycle of that block. The active bit then reads 0 and the block-error flag reads 1.
- R4: When software writes 0 to the active bit while a bus cycle is in flight, the active bit keeps reading 1 until the cycle after bus_done, and then reads 0. When the channel is idle, it reads 0 in the cycle after the write.
- R5: The interrupt-request flag rises in the same cycle that the active bit falls after the bus cycle that brings the remaining count to 0. A software stop, an NMI or a standby entry never sets the flag.
- R6: irq_out is 1 exactly while both the interrupt-request flag and the interrupt-enable bit are 1.
- R7: Writing 1 to the active bit clears the interrupt-request flag and irq_out in the next cycle.
- R8: Standby entry stops the channel at the end of the bus cycle in flight, clears the active bit and leaves the block-error flag at 0.
- R9: A transfer request that arrives while the active bit is 0 is discarded, so a later start produces no bus cycle from it. A request that arrives during a running block is held and served after that block ends.
- R10: Writing 0 to the block-error flag clears it. Writing 1 leaves it unchanged.
- R11: xfer_left decreases by one at each completed bus cycle (bus_done). With blk_mode=0, one request gives one bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_mode | input | 1 | 1: block mode, 0: single mode |
| sw_wr_act | input | 1 | Write strobe for the active bit |
| sw_act_val | input | 1 | Value written to the active bit |
| sw_wr_ie | input | 1 | Write strobe for the interrupt enable |
| sw_ie_val | input | 1 | Value written to the interrupt enable |
| sw_wr_err | input | 1 | Write strobe for the block-error flag |
| sw_err_val | input | 1 | Value written to the block-error flag (only 0 acts) |
| sw_wr_bsz | input | 1 | Write strobe for the block length |
| sw_bsz_val | input | BS_W | Block length in bus cycles |
| sw_wr_tc | input | 1 | Write strobe for the transfer count |
| sw_tc_val | input | TC_W | Transfer count |
| xfer_req | input | 1 | Transfer request from the peripheral |
| bus_start | output | 1 | One-cycle pulse that starts a bus cycle |
| bus_done | input | 1 | Pulse marking the end of the bus cycle |
| nmi | input | 1 | Non-maskable interrupt event |
| standby | input | 1 | Standby entry event |
| act_rd | output | 1 | Active bit read value |
| ie_rd | output | 1 | Interrupt enable read value |
| err_rd | output | 1 | Block-error flag |
| irq_flag_rd | output | 1 | Interrupt-request flag |
| irq_out | output | 1 | Interrupt request to the controller |
| xfer_left | output | TC_W | Remaining transfer count |

## Verification
A sequencer or counter state that is wrong shows up at bus_start. The block issues a bus cycle that should not happen, or fails to issue one, within one or two cycles of the boundary where it decides. The bench's scoreboard catches an unexpected cycle as soon as bus_start rises. A flag that is set wrong, or an early stop, shows up on act_rd, err_rd or irq_flag_rd in the cycle after the deciding bus_done. A miscounted decrement shows up on xfer_left in the cycle after each bus_done.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_st_t;

  // Number of bus cycles in one run: a whole block, or one cycle.
  function automatic logic [31:0] run_len(input logic blk, input logic [31:0] bsz);
    return blk ? bsz : 32'd1;
  endfunction

  // True when a down-counter holds its final unit.
  function automatic logic is_last(input logic [31:0] v);
    return v == 32'd1;
  endfunction

endpackage

// File: rtl/dmac_req_hold.sv
module dmac_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic xfer_req,
  input  logic run_start,
  output logic pend
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend <= 1'b0;
    else if (!act) pend <= 1'b0;
    else           pend <= (pend & ~run_start) | xfer_req;
  end

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_ctl_pkg::*;
#(
  parameter int BS_W = 8,
  parameter int TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            blk_mode,
  input  logic            sw_wr_bsz,
  input  logic [BS_W-1:0] sw_bsz_val,
  input  logic            sw_wr_tc,
  input  logic [TC_W-1:0] sw_tc_val,
  input  logic            may_start,
  input  logic            req_pend,
  input  logic            bus_done,
  input  logic            halt_now,
  output logic            bus_start,
  output logic            run_start,
  output logic            at_bound,
  output logic            run_bound,
  output logic            blk_open,
  output logic            tc_last_done,
  output logic            cyc_wait,
  output logic [TC_W-1:0] xfer_left
);

  seq_st_t         st;
  logic [BS_W-1:0] bsz_q;
  logic [BS_W-1:0] blk_rem;
  logic [TC_W-1:0] tc_rem;
  logic            done_now;
  logic            blk_last;
  logic            tc_last;
  logic            go_idle;

  assign cyc_wait     = (st == ST_WAIT);
  assign done_now     = cyc_wait & bus_done;
  assign blk_last     = is_last(32'(blk_rem));
  assign tc_last      = is_last(32'(tc_rem));
  assign at_bound     = (st == ST_IDLE) | done_now;
  assign run_bound    = (st == ST_IDLE) | (done_now & blk_last);
  assign blk_open     = blk_mode & done_now & ~blk_last & ~tc_last;
  assign tc_last_done = done_now & tc_last;
  assign run_start    = (st == ST_IDLE) & may_start & req_pend;
  assign bus_start    = (st == ST_ISSUE);
  assign go_idle      = tc_last | halt_now | blk_last;
  assign xfer_left    = tc_rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bsz_q <= '0;
    else if (sw_wr_bsz) bsz_q <= sw_bsz_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      blk_rem <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (run_start) begin
          blk_rem <= BS_W'(run_len(blk_mode, 32'(bsz_q)));
          st      <= ST_ISSUE;
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: if (bus_done) begin
          blk_rem <= blk_rem - 1'b1;
          st      <= go_idle ? ST_IDLE : ST_ISSUE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tc_rem <= '0;
    else if (sw_wr_tc) tc_rem <= sw_tc_val;
    else if (done_now) tc_rem <= tc_rem - 1'b1;
  end

endmodule

// File: rtl/dmac_flags.sv
module dmac_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr_act,
  input  logic sw_act_val,
  input  logic sw_wr_ie,
  input  logic sw_ie_val,
  input  logic sw_wr_err,
  input  logic sw_err_val,
  input  logic nmi,
  input  logic standby,
  input  logic at_bound,
  input  logic run_bound,
  input  logic blk_open,
  input  logic tc_last_done,
  output logic act_q,
  output logic ie_q,
  output logic err_q,
  output logic irq_q,
  output logic may_start,
  output logic halt_now
);

  logic stop_q, halt_q, halt_nmi_q;
  logic wr_on, wr_off;
  logic halt_req, halt_is_nmi, stop_req;
  logic stop_now, tc_end, act_clr, err_set;

  assign wr_on       = sw_wr_act & sw_act_val;
  assign wr_off      = sw_wr_act & ~sw_act_val;
  assign halt_req    = halt_q | nmi | standby;
  assign halt_is_nmi = halt_nmi_q | nmi;
  assign stop_req    = stop_q | wr_off;
  assign halt_now    = act_q & halt_req & at_bound;
  assign stop_now    = act_q & stop_req & run_bound & ~halt_now;
  assign tc_end      = act_q & tc_last_done;
  assign act_clr     = halt_now | stop_now | tc_end;
  assign err_set     = halt_now & halt_is_nmi & blk_open;
  assign may_start   = act_q & ~halt_req & ~stop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (act_clr)    act_q <= 1'b0;
      else if (wr_on) act_q <= 1'b1;
      if (act_clr || wr_on)   stop_q <= 1'b0;
      else if (wr_off && act_q) stop_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q     <= 1'b0;
      halt_nmi_q <= 1'b0;
    end else if (act_clr || !act_q) begin
      halt_q     <= 1'b0;
      halt_nmi_q <= 1'b0;
    end else begin
      if (nmi || standby) halt_q <= 1'b1;
      if (nmi)            halt_nmi_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (sw_wr_ie) ie_q <= sw_ie_val;
      if (err_set)                      err_q <= 1'b1;
      else if (sw_wr_err && !sw_err_val) err_q <= 1'b0;
      if (tc_end)     irq_q <= 1'b1;
      else if (wr_on) irq_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dmac_chan_ctrl.sv
module dmac_chan_ctrl #(
  parameter int BS_W = 8,
  parameter int TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            blk_mode,
  input  logic            sw_wr_act,
  input  logic            sw_act_val,
  input  logic            sw_wr_ie,
  input  logic            sw_ie_val,
  input  logic            sw_wr_err,
  input  logic            sw_err_val,
  input  logic            sw_wr_bsz,
  input  logic [BS_W-1:0] sw_bsz_val,
  input  logic            sw_wr_tc,
  input  logic [TC_W-1:0] sw_tc_val,
  input  logic            xfer_req,
  output logic            bus_start,
  input  logic            bus_done,
  input  logic            nmi,
  input  logic            standby,
  output logic            act_rd,
  output logic            ie_rd,
  output logic            err_rd,
  output logic            irq_flag_rd,
  output logic            irq_out,
  output logic [TC_W-1:0] xfer_left
);

  logic req_pend, run_start, may_start, halt_now;
  logic at_bound, run_bound, blk_open, tc_last_done, cyc_wait;

  dmac_req_hold u_req (
    .clk(clk), .rst_n(rst_n), .act(act_rd), .xfer_req(xfer_req),
    .run_start(run_start), .pend(req_pend)
  );

  dmac_seq #(.BS_W(BS_W), .TC_W(TC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode),
    .sw_wr_bsz(sw_wr_bsz), .sw_bsz_val(sw_bsz_val),
    .sw_wr_tc(sw_wr_tc), .sw_tc_val(sw_tc_val),
    .may_start(may_start), .req_pend(req_pend), .bus_done(bus_done),
    .halt_now(halt_now), .bus_start(bus_start), .run_start(run_start),
    .at_bound(at_bound), .run_bound(run_bound), .blk_open(blk_open),
    .tc_last_done(tc_last_done), .cyc_wait(cyc_wait), .xfer_left(xfer_left)
  );

  dmac_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .sw_wr_act(sw_wr_act), .sw_act_val(sw_act_val),
    .sw_wr_ie(sw_wr_ie), .sw_ie_val(sw_ie_val),
    .sw_wr_err(sw_wr_err), .sw_err_val(sw_err_val),
    .nmi(nmi), .standby(standby),
    .at_bound(at_bound), .run_bound(run_bound), .blk_open(blk_open),
    .tc_last_done(tc_last_done),
    .act_q(act_rd), .ie_q(ie_rd), .err_q(err_rd), .irq_q(irq_flag_rd),
    .may_start(may_start), .halt_now(halt_now)
  );

  assign irq_out = irq_flag_rd & ie_rd;

endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_wr_act,
  input logic sw_act_val,
  input logic bus_start,
  input logic bus_done,
  input logic cyc_wait,
  input logic act_rd,
  input logic err_rd,
  input logic irq_flag_rd,
  input logic irq_out,
  input logic ie_rd
);

  // R5: the request flag only rises together with the fall of the active bit
  assert_irq_with_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag_rd) |-> $fell(act_rd));

  // R3: the error flag only rises when the channel stops
  assert_err_with_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_rd) |-> $fell(act_rd));

  // R4: an unfinished bus cycle keeps the channel active
  assert_act_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_wait && !bus_done && act_rd) |=> act_rd);

  // R7: a restart write withdraws the request flag
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_act && sw_act_val) |=> !irq_flag_rd);

  // R9: no bus cycle is started by an inactive channel
  assert_no_idle_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> act_rd);

  // R11: each start is a one-cycle pulse
  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start);

  // R6: the output never asserts without enable
  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (ie_rd && irq_flag_rd));

endmodule

bind dmac_chan_ctrl dmac_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_wr_act(sw_wr_act), .sw_act_val(sw_act_val),
  .bus_start(bus_start), .bus_done(bus_done), .cyc_wait(cyc_wait),
  .act_rd(act_rd), .err_rd(err_rd), .irq_flag_rd(irq_flag_rd),
  .irq_out(irq_out), .ie_rd(ie_rd)
);

// File: tb/sim_dmac_chan_ctrl.sv
module sim_dmac_chan_ctrl;
  localparam int BS_W = 8;
  localparam int TC_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_mode = 1'b0;
  logic sw_wr_act = 1'b0, sw_act_val = 1'b0, sw_wr_ie = 1'b0, sw_ie_val = 1'b0;
  logic sw_wr_err = 1'b0, sw_err_val = 1'b0, sw_wr_bsz = 1'b0, sw_wr_tc = 1'b0;
  logic [BS_W-1:0] sw_bsz_val = '0;
  logic [TC_W-1:0] sw_tc_val = '0;
  logic xfer_req = 1'b0, bus_done = 1'b0, nmi = 1'b0, standby = 1'b0;
  logic bus_start, act_rd, ie_rd, err_rd, irq_flag_rd, irq_out;
  logic [TC_W-1:0] xfer_left;

  int n_chk = 0, n_fail = 0, n_start = 0;
  int bus_lat = 2, wait_ctr = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  dmac_chan_ctrl #(.BS_W(BS_W), .TC_W(TC_W)) u0 (.*);

  task automatic check(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_cycle(int left);
    exp_q.push_back(left);
  endtask

  task automatic wr_act(logic v);
    sw_wr_act = 1'b1; sw_act_val = v; tick(1); sw_wr_act = 1'b0;
  endtask

  task automatic wr_ie(logic v);
    sw_wr_ie = 1'b1; sw_ie_val = v; tick(1); sw_wr_ie = 1'b0;
  endtask

  task automatic wr_err(logic v);
    sw_wr_err = 1'b1; sw_err_val = v; tick(1); sw_wr_err = 1'b0;
  endtask

  task automatic setup(logic blk, int bsz, int tc, logic load_tc);
    blk_mode = blk;
    sw_wr_bsz = 1'b1; sw_bsz_val = BS_W'(bsz);
    sw_wr_tc = load_tc; sw_tc_val = TC_W'(tc);
    tick(1);
    sw_wr_bsz = 1'b0; sw_wr_tc = 1'b0;
  endtask

  task automatic pulse_req();
    xfer_req = 1'b1; tick(1); xfer_req = 1'b0;
  endtask

  task automatic wait_starts(int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (bus_start) seen++;
    end
  endtask

  // bus responder and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_done) begin
        bus_done = 1'b0;
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R11: bus cycle completed with no expectation, got left %0d expected none", xfer_left);
        end else begin
          check("R11 count after cycle", xfer_left, exp_q.pop_front());
        end
      end
      if (wait_ctr > 0) begin
        wait_ctr--;
        if (wait_ctr == 0) bus_done = 1'b1;
      end
      if (bus_start) begin
        n_start++;
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R9: unexpected bus cycle, got start count %0d expected %0d", n_start, n_start - 1);
        end
        wait_ctr = bus_lat;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int base;
    tick(3);
    // R1 reset state
    check("R1 act", act_rd, 0); check("R1 ie", ie_rd, 0);
    check("R1 err", err_rd, 0); check("R1 irq flag", irq_flag_rd, 0);
    check("R1 irq out", irq_out, 0); check("R1 start", bus_start, 0);
    check("R1 left", xfer_left, 0);
    rst_n = 1'b1;
    tick(2);

    // R2/R9/R11: block mode, held request, count exhaustion
    setup(1'b1, 3, 7, 1'b1);
    wr_ie(1'b1);
    wr_act(1'b1);
    base = n_start;
    for (int i = 6; i >= 1; i--) expect_cycle(i);
    pulse_req();
    tick(4);
    pulse_req();                       // R9 held during the block
    tick(40);
    check("R2 two blocks of three", n_start - base, 6);
    check("R5 still active", act_rd, 1);
    check("R5 no flag yet", irq_flag_rd, 0);
    expect_cycle(0);
    pulse_req();
    tick(15);
    check("R5 act cleared at end of count", act_rd, 0);
    check("R5 flag set", irq_flag_rd, 1);
    check("R6 irq out", irq_out, 1);
    check("R3 no error on normal end", err_rd, 0);
    check("R11 seven cycles", n_start - base, 7);
    check("R11 queue drained", exp_q.size(), 0);
    wr_ie(1'b0);
    check("R6 masked", irq_out, 0);
    check("R6 flag kept", irq_flag_rd, 1);
    wr_ie(1'b1);
    check("R6 unmasked", irq_out, 1);

    // R9: request while inactive is discarded
    base = n_start;
    pulse_req();
    tick(10);
    check("R9 no cycle when inactive", n_start - base, 0);
    // R7: restart clears the flag
    setup(1'b1, 4, 10, 1'b1);
    wr_act(1'b1);
    check("R7 flag cleared", irq_flag_rd, 0);
    check("R7 irq out cleared", irq_out, 0);
    check("R7 active", act_rd, 1);
    tick(10);
    check("R9 stale request not served", n_start - base, 0);

    // R3: NMI during a block
    expect_cycle(9); expect_cycle(8);
    pulse_req();
    wait_starts(2);
    nmi = 1'b1; tick(1); nmi = 1'b0;
    check("R3 active while cycle in flight", act_rd, 1);
    tick(10);
    check("R3 act cleared", act_rd, 0);
    check("R3 error set", err_rd, 1);
    check("R5 no flag on nmi", irq_flag_rd, 0);
    check("R3 two cycles only", n_start - base, 2);
    check("R3 left", xfer_left, 8);

    // R10: error flag writes
    wr_err(1'b1);
    check("R10 write one ignored", err_rd, 1);
    wr_err(1'b0);
    check("R10 write zero clears", err_rd, 0);

    // R8: standby during a block
    wr_act(1'b1);
    base = n_start;
    expect_cycle(7);
    pulse_req();
    wait_starts(1);
    standby = 1'b1; tick(1); standby = 1'b0;
    tick(10);
    check("R8 act cleared", act_rd, 0);
    check("R8 no error", err_rd, 0);
    check("R8 one cycle", n_start - base, 1);
    check("R5 no flag on standby", irq_flag_rd, 0);

    // R4: software stop with a cycle in flight, single mode
    setup(1'b0, 4, 0, 1'b0);
    bus_lat = 6;
    wr_act(1'b1);
    base = n_start;
    expect_cycle(6);
    pulse_req();
    wait_starts(1);
    wr_act(1'b0);
    check("R4 still active next cycle", act_rd, 1);
    tick(2);
    check("R4 still active in flight", act_rd, 1);
    tick(6);
    check("R4 cleared after done", act_rd, 0);
    check("R11 single mode one cycle", n_start - base, 1);
    // R4: idle stop is immediate
    bus_lat = 2;
    wr_act(1'b1);
    wr_act(1'b0);
    check("R4 idle stop next cycle", act_rd, 0);

    // R2: stop written during a block waits for the block
    setup(1'b1, 3, 0, 1'b0);
    wr_act(1'b1);
    base = n_start;
    expect_cycle(5); expect_cycle(4); expect_cycle(3);
    pulse_req();
    wait_starts(1);
    wr_act(1'b0);
    check("R2 active after stop write", act_rd, 1);
    tick(25);
    check("R2 full block after stop", n_start - base, 3);
    check("R2 act cleared", act_rd, 0);
    check("R5 no flag on stop", irq_flag_rd, 0);
    check("R11 left", xfer_left, 3);

    summary();
  end
endmodule